// File: doc/BRIEF.md
# Programmed-IO Data FIFO with Command Capture

This block is the byte buffer that sits behind a host-visible FIFO data port of a bus-initiator controller. Host byte writes normally enter a small data queue, and host byte reads pop that queue while the bus is in a data-in phase. While a command-capture mode input is held high, host writes go instead into a separate command buffer. The controller reads that buffer back by address once the command bytes are complete.

The queue rejects a write once it already holds `DEPTH-1` bytes and raises a sticky overrun flag. Both queue pointers snap back to zero whenever the occupancy reaches zero. A response-load strobe replaces the queue contents with a two-byte status/message pair, ready to be read out.

A start-of-command strobe empties the queue. Each successful pop and each response load produce a one-cycle interrupt-request pulse. Only one queue operation takes effect per cycle, chosen by a fixed priority.

Top module: `pio_data_fifo`

## Requirements
- R1: After a synchronous reset, `count`, `flags`, `overrun`, `irq`, `rd_data` and `cmd_len` are all zero.
- R2: A write with `cmd_mode` low and `count` below `DEPTH-1` stores the byte and raises `count` by one. The queue is first-in first-out.
- R3: A write with `cmd_mode` low while `count` equals `DEPTH-1` stores nothing and leaves `count` unchanged. It sets `overrun`, which stays set until a `flush` pulse or reset. A `flush` also clears `flags` to 0 and does not change `count`.
- R4: A read with nonzero `count` while `phase[2:1]` is nonzero returns the oldest byte on `rd_data` one cycle later and lowers `count` by one. It also pulses `irq` high for one cycle.
- R5: A read with nonzero `count` while `phase[2:1]` equals 2'b00 (data-out) returns 0. It lowers `count` by one and pulses `irq`, but does not advance the read pointer, so the next data-in read returns the byte that was pending.
- R6: A read with `count` equal to zero leaves `rd_data` at its previous value, keeps `count` at 0 and produces no `irq`.
- R7: When a read brings `count` to zero, both queue pointers return to zero, so the next written byte is the next byte read even after data-out reads.
- R8: A write with `cmd_mode` high stores the byte at command-buffer index `cmd_len` and raises `cmd_len` by one, up to `CMD_DEPTH`. Writes beyond that are dropped. `count` does not change. `cmd_clr` sets `cmd_len` to 0. `cmd_rdata` shows the entry at `cmd_raddr` one cycle later.
- R9: A `rsp_load` pulse makes the queue hold `rsp_status` followed by 0x00. It sets `count` to 2 and `flags` to 2 and pulses `irq`.
- R10: A `new_cmd` pulse sets `count` to 0 and both queue pointers to 0.
- R11: When several requests arrive in one cycle, only the highest-priority one acts, in the order `rsp_load`, `new_cmd`, write, read. `flush` acts alongside them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | DW | Host write byte |
| rd_en | input | 1 | Host byte read strobe |
| phase | input | 3 | Current bus phase; bits 2:1 equal to 00 means data-out |
| cmd_mode | input | 1 | Steers writes into the command buffer |
| new_cmd | input | 1 | Start of a new command: empties the queue |
| flush | input | 1 | Clears the overrun flag and the flags readback |
| rsp_load | input | 1 | Loads the two-byte response into the queue |
| rsp_status | input | DW | Status byte for the response |
| cmd_clr | input | 1 | Empties the command buffer |
| cmd_raddr | input | CAW | Command buffer read index |
| rd_data | output | DW | Byte returned by the last effective read |
| count | output | CW | Queue occupancy |
| flags | output | CW | Flags readback value |
| overrun | output | 1 | Sticky write-overrun flag |
| irq | output | 1 | One-cycle interrupt-request pulse |
| cmd_len | output | CLW | Number of captured command bytes |
| cmd_rdata | output | DW | Command buffer byte at `cmd_raddr` |

## Verification
The assertions assume that the inputs are sampled as single-cycle strobes at the rising edge and that `phase` is stable whenever `rd_en` is high. Several of them also state their antecedents with the higher-priority strobes low, so they rely on the priority order instead of on inputs being mutually exclusive. The stimulus drives every strobe for exactly one cycle from the falling edge and returns all strobes to zero between operations. It combines strobes only in the dedicated priority cases, where each combination is chosen deliberately.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_RSP,
    OP_CLEAR,
    OP_WR_DATA,
    OP_WR_CMD,
    OP_RD
  } fifo_op_e;
endpackage

// File: rtl/pio_fifo_ctrl.sv
module pio_fifo_ctrl
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  fifo_op_e      op,
  input  logic          flush,
  input  logic          data_out_phase,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic          rd_fire,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] count,
  output logic [CW-1:0] flags,
  output logic          overrun,
  output logic          irq
);
  logic [AW-1:0] rptr, wptr;
  logic          at_limit;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign at_limit  = (count == CW'(DEPTH - 1));
  assign mem_we    = (op == OP_WR_DATA) && !at_limit;
  assign mem_waddr = wptr;
  assign rd_fire   = (op == OP_RD) && (count != '0);
  assign rd_addr   = rptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      rptr    <= '0;
      wptr    <= '0;
      flags   <= '0;
      overrun <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= rd_fire || (op == OP_RSP);
      if ((op == OP_WR_DATA) && at_limit) overrun <= 1'b1;
      else if (flush)                     overrun <= 1'b0;
      if (op == OP_RSP)  flags <= CW'(2);
      else if (flush)    flags <= '0;
      case (op)
        OP_RSP: begin
          count <= CW'(2);
          rptr  <= '0;
          wptr  <= AW'(2);
        end
        OP_CLEAR: begin
          count <= '0;
          rptr  <= '0;
          wptr  <= '0;
        end
        OP_WR_DATA: begin
          if (!at_limit) begin
            count <= count + CW'(1);
            wptr  <= step(wptr);
          end
        end
        OP_RD: begin
          if (count != '0) begin
            count <= count - CW'(1);
            if (count == CW'(1)) begin
              rptr <= '0;
              wptr <= '0;
            end else if (!data_out_phase) begin
              rptr <= step(rptr);
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pio_fifo_store.sv
module pio_fifo_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rsp_load,
  input  logic [DW-1:0] rsp_status,
  input  logic          rd_fire,
  input  logic          rd_zero,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rsp_load) begin
      mem[0] <= rsp_status;
      mem[1] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_data <= '0;
    else if (rd_fire) rd_data <= rd_zero ? '0 : mem[raddr];
  end
endmodule

// File: rtl/pio_cmd_capture.sv
module pio_cmd_capture #(
  parameter int CMD_DEPTH = 16,
  parameter int DW        = 8,
  localparam int CAW = $clog2(CMD_DEPTH),
  localparam int CLW = $clog2(CMD_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [DW-1:0]  wdata,
  input  logic           clr,
  input  logic [CAW-1:0] raddr,
  output logic [CLW-1:0] len,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] cbuf [CMD_DEPTH];
  logic          room;

  assign room = (len < CLW'(CMD_DEPTH));

  always_ff @(posedge clk) begin
    if (we && room && !clr) cbuf[CAW'(len)] <= wdata;
    rdata <= cbuf[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr)      len <= '0;
    else if (we && room) len <= len + CLW'(1);
  end
endmodule

// File: rtl/pio_data_fifo.sv
module pio_data_fifo
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 16,
  parameter int DW        = 8,
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int CAW = $clog2(CMD_DEPTH),
  localparam int CLW = $clog2(CMD_DEPTH + 1),
  localparam int AW  = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_en,
  input  logic [2:0]     phase,
  input  logic           cmd_mode,
  input  logic           new_cmd,
  input  logic           flush,
  input  logic           rsp_load,
  input  logic [DW-1:0]  rsp_status,
  input  logic           cmd_clr,
  input  logic [CAW-1:0] cmd_raddr,
  output logic [DW-1:0]  rd_data,
  output logic [CW-1:0]  count,
  output logic [CW-1:0]  flags,
  output logic           overrun,
  output logic           irq,
  output logic [CLW-1:0] cmd_len,
  output logic [DW-1:0]  cmd_rdata
);
  fifo_op_e      op;
  logic          data_out_phase;
  logic          mem_we, rd_fire;
  logic [AW-1:0] mem_waddr, rd_addr;

  assign data_out_phase = (phase[2:1] == 2'b00);

  always_comb begin
    op = OP_IDLE;
    if (rsp_load)     op = OP_RSP;
    else if (new_cmd) op = OP_CLEAR;
    else if (wr_en)   op = cmd_mode ? OP_WR_CMD : OP_WR_DATA;
    else if (rd_en)   op = OP_RD;
  end

  pio_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .op(op), .flush(flush),
    .data_out_phase(data_out_phase),
    .mem_we(mem_we), .mem_waddr(mem_waddr),
    .rd_fire(rd_fire), .rd_addr(rd_addr),
    .count(count), .flags(flags), .overrun(overrun), .irq(irq)
  );

  pio_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
    .rsp_load(op == OP_RSP), .rsp_status(rsp_status),
    .rd_fire(rd_fire), .rd_zero(data_out_phase), .raddr(rd_addr),
    .rd_data(rd_data)
  );

  pio_cmd_capture #(.CMD_DEPTH(CMD_DEPTH), .DW(DW)) u_cmd (
    .clk(clk), .rst(rst), .we(op == OP_WR_CMD), .wdata(wr_data),
    .clr(cmd_clr), .raddr(cmd_raddr), .len(cmd_len), .rdata(cmd_rdata)
  );
endmodule

// File: rtl/pio_data_fifo_chk.sv
module pio_data_fifo_chk #(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 16,
  parameter int DW        = 8,
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int CLW = $clog2(CMD_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic           rd_en,
  input logic           cmd_mode,
  input logic           new_cmd,
  input logic           flush,
  input logic           rsp_load,
  input logic           cmd_clr,
  input logic [DW-1:0]  rd_data,
  input logic [CW-1:0]  count,
  input logic [CW-1:0]  flags,
  input logic           overrun,
  input logic           irq,
  input logic [CLW-1:0] cmd_len
);
  // R3
  count_limit_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH - 1));

  // R3
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun && !flush |=> overrun);

  // R3
  overrun_reject_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && !cmd_mode && !rsp_load && !new_cmd && (count == CW'(DEPTH - 1))
    |=> overrun && (count == CW'(DEPTH - 1)));

  // R9
  rsp_load_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_load |=> (count == CW'(2)) && (flags == CW'(2)) && irq);

  // R10
  new_cmd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    new_cmd && !rsp_load |=> count == '0);

  // R4
  rd_pop_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && !wr_en && !new_cmd && !rsp_load && (count != '0)
    |=> irq && (count == $past(count) - CW'(1)));

  // R6
  rd_empty_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && !wr_en && !new_cmd && !rsp_load && (count == '0)
    |=> !irq && (count == '0) && $stable(rd_data));

  // R8
  cmd_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && cmd_mode && !rsp_load && !new_cmd |=> $stable(count));

  // R8
  cmd_len_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_len <= CLW'(CMD_DEPTH));
endmodule

bind pio_data_fifo pio_data_fifo_chk #(
  .DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH), .DW(DW)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .cmd_mode(cmd_mode),
  .new_cmd(new_cmd), .flush(flush), .rsp_load(rsp_load), .cmd_clr(cmd_clr),
  .rd_data(rd_data), .count(count), .flags(flags), .overrun(overrun),
  .irq(irq), .cmd_len(cmd_len)
);

// File: tb/tb_pio_data_fifo.sv
`timescale 1ns/1ps
module tb_pio_data_fifo;
  localparam int DEPTH = 16;
  localparam int CMD_DEPTH = 16;
  localparam int DW = 8;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int CAW = $clog2(CMD_DEPTH);
  localparam int CLW = $clog2(CMD_DEPTH + 1);
  localparam logic [2:0] PH_IN  = 3'b011;
  localparam logic [2:0] PH_OUT = 3'b000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, rd_en = 0, cmd_mode = 0, new_cmd = 0, flush = 0;
  logic rsp_load = 0, cmd_clr = 0;
  logic [DW-1:0] wr_data = '0, rsp_status = '0;
  logic [2:0] phase = PH_IN;
  logic [CAW-1:0] cmd_raddr = '0;
  logic [DW-1:0] rd_data, cmd_rdata;
  logic [CW-1:0] count, flags;
  logic overrun, irq;
  logic [CLW-1:0] cmd_len;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pio_data_fifo #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH), .DW(DW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .phase(phase), .cmd_mode(cmd_mode), .new_cmd(new_cmd), .flush(flush),
    .rsp_load(rsp_load), .rsp_status(rsp_status), .cmd_clr(cmd_clr),
    .cmd_raddr(cmd_raddr), .rd_data(rd_data), .count(count), .flags(flags),
    .overrun(overrun), .irq(irq), .cmd_len(cmd_len), .cmd_rdata(cmd_rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_strobes();
    wr_en = 0; rd_en = 0; new_cmd = 0; flush = 0; rsp_load = 0; cmd_clr = 0;
  endtask

  task automatic step();
    @(negedge clk);
    clear_strobes();
  endtask

  task automatic wr(input logic [DW-1:0] b);
    wr_en = 1; wr_data = b; step();
  endtask

  task automatic rd(input logic [2:0] ph);
    rd_en = 1; phase = ph; step();
  endtask

  function automatic logic [DW-1:0] pat(input int n, input int i);
    return DW'((n * 37 + i * 11 + 5) & 255);
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 flags", flags, 0);
    check("R1 overrun", overrun, 0);
    check("R1 irq", irq, 0);
    check("R1 rd_data", rd_data, 0);
    check("R1 cmd_len", cmd_len, 0);

    // R2 / R4 sweep over every occupancy
    for (int n = 1; n <= DEPTH - 1; n++) begin
      for (int i = 0; i < n; i++) begin
        wr(pat(n, i));
        check("R2 count after write", count, i + 1);
      end
      for (int i = 0; i < n; i++) begin
        rd(PH_IN);
        check("R4 data", rd_data, pat(n, i));
        check("R4 irq", irq, 1);
        check("R4 count", count, n - i - 1);
      end
      check("R3 no overrun", overrun, 0);
    end

    // R3 overrun at DEPTH-1
    for (int i = 0; i < DEPTH - 1; i++) wr(pat(99, i));
    check("R3 full count", count, DEPTH - 1);
    wr(8'hEE);
    check("R3 overrun set", overrun, 1);
    check("R3 count held", count, DEPTH - 1);
    step();
    check("R3 overrun sticky", overrun, 1);
    for (int i = 0; i < DEPTH - 1; i++) begin
      rd(PH_IN);
      check("R3 rejected byte not stored", rd_data, pat(99, i));
    end
    check("R3 overrun still set", overrun, 1);
    wr(8'h11);
    flush = 1; step();
    check("R3 flush clears overrun", overrun, 0);
    check("R3 flush keeps count", count, 1);
    check("R3 flush flags", flags, 0);

    // R10 new command empties
    new_cmd = 1; step();
    check("R10 count", count, 0);

    // R5 data-out read
    wr(8'hA1); wr(8'hB2);
    rd(PH_OUT);
    check("R5 zero data", rd_data, 0);
    check("R5 irq", irq, 1);
    check("R5 count", count, 1);
    rd(PH_IN);
    check("R5 pointer held", rd_data, 8'hA1);
    check("R5 count empty", count, 0);

    // R6 read while empty
    step();
    rd(PH_IN);
    check("R6 data held", rd_data, 8'hA1);
    check("R6 no irq", irq, 0);
    check("R6 count", count, 0);

    // R7 pointers snap to zero on empty
    wr(8'h31); wr(8'h42);
    rd(PH_OUT); rd(PH_OUT);
    check("R7 count", count, 0);
    wr(8'h53);
    rd(PH_IN);
    check("R7 realigned", rd_data, 8'h53);

    // R10 pointers cleared by new command
    wr(8'h61); wr(8'h72);
    rd(PH_OUT);
    new_cmd = 1; step();
    check("R10 count cleared", count, 0);
    wr(8'h83);
    rd(PH_IN);
    check("R10 realigned", rd_data, 8'h83);

    // R9 response load
    rsp_status = 8'h5A; rsp_load = 1; step();
    check("R9 count", count, 2);
    check("R9 flags", flags, 2);
    check("R9 irq", irq, 1);
    rd(PH_IN);
    check("R9 status byte", rd_data, 8'h5A);
    rd(PH_IN);
    check("R9 message byte", rd_data, 0);
    flush = 1; step();
    check("R3 flush flags after load", flags, 0);

    // R8 command capture
    cmd_mode = 1;
    for (int i = 0; i < CMD_DEPTH + 2; i++) begin
      wr(pat(7, i));
      check("R8 count unchanged", count, 0);
      check("R8 cmd_len", cmd_len, (i + 1 < CMD_DEPTH) ? i + 1 : CMD_DEPTH);
    end
    cmd_mode = 0;
    for (int i = 0; i < CMD_DEPTH; i++) begin
      cmd_raddr = CAW'(i);
      @(negedge clk);
      check("R8 cmd byte", cmd_rdata, pat(7, i));
    end
    cmd_clr = 1; step();
    check("R8 cmd_clr", cmd_len, 0);

    // R11 priority
    rsp_status = 8'h3C; rsp_load = 1; wr_en = 1; wr_data = 8'h99; step();
    check("R11 load over write count", count, 2);
    rd(PH_IN);
    check("R11 load over write data", rd_data, 8'h3C);
    new_cmd = 1; wr_en = 1; wr_data = 8'h77; step();
    check("R11 new_cmd over write", count, 0);
    wr(8'h12);
    wr_en = 1; wr_data = 8'h34; rd_en = 1; phase = PH_IN; step();
    check("R11 write over read", count, 2);
    check("R11 no irq", irq, 0);
    rd(PH_IN);
    check("R11 order", rd_data, 8'h12);
    rd(PH_IN);
    check("R11 order second", rd_data, 8'h34);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule